// File: doc/BRIEF.md
# Encoded Microcode Sequencer

This block is the control half of a small microcoded processor. It keeps a micro-program-counter (the micro-address) and reads a combinational control store at that address. Each control word carries a vector of datapath control lines and a 3-bit jump-type code. The control store holds no next address. The jump code tells a small piece of next-address logic how to form the following micro-address from the current one, from an opcode dispatch decoder, from a condition input and from a memory busy input.

The control store holds the instruction fetch sequence and five instruction groups: register-register ALU, register-immediate ALU, word load, jump-and-link and conditional branch. An opcode that matches no group sends the sequencer to a trap word that loops on itself and raises an illegal-instruction flag until the next reset. The datapath that consumes the control lines is outside this block.

Micro-address map: fetch 0..2, ALU 3..5, ALU-immediate 6..8, load 9..13, jump-and-link 14..17, branch 18..23, trap 24.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low the micro-address is 0 (fetch0), and the control word at fetch0 has the memory-address-load bit [17] and the A-load bit [16] set.
- R2: A step with the "next" jump type moves to the current micro-address plus one, whatever `busy_i` and `cond_i` are; this covers fetch0 and every group step that is not a spin, dispatch, conditional or group-final step.
- R3: The spin steps, fetch1 (address 1) and the load memory step (address 12), keep the micro-address unchanged in every cycle that `busy_i` is high and advance by one in the first cycle it is low.
- R4: The final step of each group (addresses 5, 8, 13, 17, 23) returns to fetch0 on the next cycle.
- R5: At fetch2 (address 2) the next micro-address comes from the opcode: 5'h0C goes to 3 (ALU), 5'h04 to 6 (ALU-immediate), 5'h00 to 9 (load), 5'h1B to 14 (jump-and-link), 5'h18 to 18 (branch).
- R6: Branch step address 20 uses the "jump to fetch when condition false" type: with `cond_i` low the next address is 0, with `cond_i` high it is 21, after which the branch runs 21, 22, 23 and returns to fetch0.
- R7: Any other opcode at fetch2 sends the sequencer to address 24, where it stays with `illegal_o` high until reset; `illegal_o` is low at every other address.
- R8: Control word fields: [17] memory-address load, [16] A load, [15] B load, [14] instruction-register load, [13] PC load, [12] register write, [11] register enable, [10] memory enable, [9] memory write, [8] ALU enable, [7] immediate enable, [6:5] register select, [4:3] immediate select, [2:0] ALU operation (1 means A+4). Fetch1 sets bit 14, fetch2 sets bit 13 with ALU operation 1, and bit 9 is never set by any step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | OP_W (5) | Major opcode of the instruction held in the instruction register |
| cond_i | input | 1 | Condition result from the datapath |
| busy_i | input | 1 | Memory busy |
| ctrl_o | output | 18 | Datapath control lines of the current control word |
| upc_o | output | UPC_W (6) | Current micro-address |
| illegal_o | output | 1 | High while the sequencer sits in the trap word |

## Verification
The bench sweeps all 32 opcodes, each with memory wait counts of zero, one and two and with both condition values, and walks every sequence step by step against an address path worked out from the map. It targets the spin steps, where a design that advanced on busy or stalled after busy dropped would shift every later step by a cycle; the dispatch decoder, where a wrong table entry would start the wrong group or miss the trap; the conditional branch step, where an inverted sense would run the taken path on a not-taken branch; and the trap, where a leaky hold would let an illegal opcode wander back into fetch. Busy is held high on every non-spin step so that a design that stalled there is caught too.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;

   typedef enum logic [2:0] {
      JT_NEXT   = 3'd0,
      JT_SPIN   = 3'd1,
      JT_FETCH  = 3'd2,
      JT_DISP   = 3'd3,
      JT_FTRUE  = 3'd4,
      JT_FFALSE = 3'd5,
      JT_HOLD   = 3'd6
   } jump_e;

   typedef struct packed {
      logic       ma_ld;
      logic       a_ld;
      logic       b_ld;
      logic       ir_ld;
      logic       pc_ld;
      logic       reg_wr;
      logic       reg_en;
      logic       mem_en;
      logic       mem_wr;
      logic       alu_en;
      logic       imm_en;
      logic [1:0] reg_sel;
      logic [1:0] imm_sel;
      logic [2:0] alu_op;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   // register select
   localparam logic [1:0] RS_PC  = 2'd0;
   localparam logic [1:0] RS_RS1 = 2'd1;
   localparam logic [1:0] RS_RS2 = 2'd2;
   localparam logic [1:0] RS_RD  = 2'd3;
   // immediate select
   localparam logic [1:0] IS_I = 2'd0;
   localparam logic [1:0] IS_J = 2'd1;
   localparam logic [1:0] IS_B = 2'd2;
   // ALU operation
   localparam logic [2:0] AO_PASS = 3'd0;
   localparam logic [2:0] AO_ADD4 = 3'd1;
   localparam logic [2:0] AO_SUB4 = 3'd2;
   localparam logic [2:0] AO_ADD  = 3'd3;
   localparam logic [2:0] AO_FUNC = 3'd4;

   // micro-address map
   localparam int unsigned A_FETCH0 = 0;
   localparam int unsigned A_FETCH1 = 1;
   localparam int unsigned A_FETCH2 = 2;
   localparam int unsigned A_ALU    = 3;
   localparam int unsigned A_ALUI   = 6;
   localparam int unsigned A_LW     = 9;
   localparam int unsigned A_JAL    = 14;
   localparam int unsigned A_BR     = 18;
   localparam int unsigned A_TRAP   = 24;
   localparam int unsigned N_WORDS  = 25;

   // opcodes
   localparam logic [4:0] OPC_ALU  = 5'h0C;
   localparam logic [4:0] OPC_ALUI = 5'h04;
   localparam logic [4:0] OPC_LW   = 5'h00;
   localparam logic [4:0] OPC_JAL  = 5'h1B;
   localparam logic [4:0] OPC_BR   = 5'h18;

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
   import ucode_seq_pkg::*;
#(
   parameter int unsigned UPC_W = 6
) (
   input  logic [UPC_W-1:0] upc,
   output ctrl_t            ctrl,
   output jump_e            jt
);

   int unsigned addr;

   always_comb begin
      addr = int'(upc);
      ctrl = '0;
      jt   = JT_FETCH;
      case (addr)
         A_FETCH0: begin
            ctrl.ma_ld = 1'b1; ctrl.a_ld = 1'b1; ctrl.reg_en = 1'b1;
            ctrl.reg_sel = RS_PC; jt = JT_NEXT;
         end
         A_FETCH1: begin
            ctrl.ir_ld = 1'b1; ctrl.mem_en = 1'b1; jt = JT_SPIN;
         end
         A_FETCH2: begin
            ctrl.pc_ld = 1'b1; ctrl.alu_en = 1'b1; ctrl.alu_op = AO_ADD4;
            jt = JT_DISP;
         end
         A_ALU, A_ALUI, A_LW, A_BR: begin
            ctrl.a_ld = 1'b1; ctrl.reg_en = 1'b1; ctrl.reg_sel = RS_RS1;
            jt = JT_NEXT;
         end
         A_ALU + 1, A_BR + 1: begin
            ctrl.b_ld = 1'b1; ctrl.reg_en = 1'b1; ctrl.reg_sel = RS_RS2;
            jt = JT_NEXT;
         end
         A_ALUI + 1, A_LW + 1: begin
            ctrl.b_ld = 1'b1; ctrl.imm_en = 1'b1; ctrl.imm_sel = IS_I;
            jt = JT_NEXT;
         end
         A_ALU + 2, A_ALUI + 2: begin
            ctrl.reg_wr = 1'b1; ctrl.reg_en = 1'b1; ctrl.reg_sel = RS_RD;
            ctrl.alu_en = 1'b1; ctrl.alu_op = AO_FUNC; jt = JT_FETCH;
         end
         A_LW + 2: begin
            ctrl.ma_ld = 1'b1; ctrl.alu_en = 1'b1; ctrl.alu_op = AO_ADD;
            jt = JT_NEXT;
         end
         A_LW + 3: begin
            ctrl.reg_wr = 1'b1; ctrl.reg_en = 1'b1; ctrl.reg_sel = RS_RD;
            ctrl.mem_en = 1'b1; jt = JT_SPIN;
         end
         A_LW + 4: jt = JT_FETCH;
         A_JAL: begin
            ctrl.reg_wr = 1'b1; ctrl.reg_en = 1'b1; ctrl.reg_sel = RS_RD;
            ctrl.alu_en = 1'b1; ctrl.alu_op = AO_PASS; jt = JT_NEXT;
         end
         A_JAL + 1, A_BR + 3: begin
            ctrl.a_ld = 1'b1; ctrl.alu_en = 1'b1; ctrl.alu_op = AO_SUB4;
            jt = JT_NEXT;
         end
         A_JAL + 2: begin
            ctrl.b_ld = 1'b1; ctrl.imm_en = 1'b1; ctrl.imm_sel = IS_J;
            jt = JT_NEXT;
         end
         A_JAL + 3, A_BR + 5: begin
            ctrl.pc_ld = 1'b1; ctrl.alu_en = 1'b1; ctrl.alu_op = AO_ADD;
            jt = JT_FETCH;
         end
         A_BR + 2: begin
            ctrl.a_ld = 1'b1; ctrl.reg_en = 1'b1; ctrl.reg_sel = RS_PC;
            jt = JT_FFALSE;
         end
         A_BR + 4: begin
            ctrl.b_ld = 1'b1; ctrl.imm_en = 1'b1; ctrl.imm_sel = IS_B;
            jt = JT_NEXT;
         end
         A_TRAP: jt = JT_HOLD;
         default: jt = JT_FETCH;
      endcase
   end

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
   import ucode_seq_pkg::*;
#(
   parameter int unsigned UPC_W   = 6,
   parameter int unsigned OP_W    = 5,
   parameter bit          TRAP_EN = 1'b1
) (
   input  logic [OP_W-1:0]  opcode,
   output logic [UPC_W-1:0] target
);

   localparam logic [UPC_W-1:0] MISS_ADDR =
      TRAP_EN ? UPC_W'(A_TRAP) : UPC_W'(A_FETCH0);

   always_comb begin
      case (opcode)
         OP_W'(OPC_ALU):  target = UPC_W'(A_ALU);
         OP_W'(OPC_ALUI): target = UPC_W'(A_ALUI);
         OP_W'(OPC_LW):   target = UPC_W'(A_LW);
         OP_W'(OPC_JAL):  target = UPC_W'(A_JAL);
         OP_W'(OPC_BR):   target = UPC_W'(A_BR);
         default:         target = MISS_ADDR;
      endcase
   end

endmodule

// File: rtl/ucode_next.sv
module ucode_next
   import ucode_seq_pkg::*;
#(
   parameter int unsigned UPC_W = 6
) (
   input  jump_e            jt,
   input  logic [UPC_W-1:0] upc,
   input  logic [UPC_W-1:0] disp,
   input  logic             cond,
   input  logic             busy,
   output logic [UPC_W-1:0] nxt
);

   localparam logic [UPC_W-1:0] FETCH0 = UPC_W'(A_FETCH0);

   logic [UPC_W-1:0] inc;
   assign inc = upc + UPC_W'(1);

   always_comb begin
      case (jt)
         JT_NEXT:   nxt = inc;
         JT_SPIN:   nxt = busy ? upc : inc;
         JT_FETCH:  nxt = FETCH0;
         JT_DISP:   nxt = disp;
         JT_FTRUE:  nxt = cond ? FETCH0 : inc;
         JT_FFALSE: nxt = cond ? inc : FETCH0;
         JT_HOLD:   nxt = upc;
         default:   nxt = FETCH0;
      endcase
   end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
   import ucode_seq_pkg::*;
#(
   parameter int unsigned UPC_W   = 6,
   parameter int unsigned OP_W    = 5,
   parameter bit          TRAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic              cond_i,
   input  logic              busy_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [UPC_W-1:0]  upc_o,
   output logic              illegal_o
);

   localparam int unsigned MAX_WORDS = 1 << UPC_W;

   if (MAX_WORDS < N_WORDS) begin : g_bad_upc
      $error("UPC_W too small for the control store map");
   end
   if (OP_W != 5) begin : g_bad_op
      $error("OP_W must be 5 to match the dispatch table");
   end

   logic [UPC_W-1:0] upc_q;
   logic [UPC_W-1:0] upc_d;
   logic [UPC_W-1:0] disp;
   ctrl_t            ctrl;
   jump_e            jt;

   ucode_rom #(.UPC_W(UPC_W)) u_rom (
      .upc  (upc_q),
      .ctrl (ctrl),
      .jt   (jt)
   );

   ucode_dispatch #(.UPC_W(UPC_W), .OP_W(OP_W), .TRAP_EN(TRAP_EN)) u_disp (
      .opcode (opcode_i),
      .target (disp)
   );

   ucode_next #(.UPC_W(UPC_W)) u_next (
      .jt   (jt),
      .upc  (upc_q),
      .disp (disp),
      .cond (cond_i),
      .busy (busy_i),
      .nxt  (upc_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc_q <= UPC_W'(A_FETCH0);
      else        upc_q <= upc_d;
   end

   if (TRAP_EN) begin : g_trap
      assign illegal_o = (upc_q == UPC_W'(A_TRAP));
   end else begin : g_no_trap
      assign illegal_o = 1'b0;
   end

   assign ctrl_o = ctrl;
   assign upc_o  = upc_q;

endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk
   import ucode_seq_pkg::*;
#(
   parameter int unsigned UPC_W = 6,
   parameter int unsigned OP_W  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [UPC_W-1:0] upc,
   input logic [OP_W-1:0]  opcode,
   input logic             cond,
   input logic             busy,
   input logic             illegal,
   input logic             mem_wr
);

   p_reset_r1: assert property (@(posedge clk) !rst_n |-> upc == UPC_W'(A_FETCH0));

   p_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      upc == UPC_W'(A_FETCH0) |=> upc == UPC_W'(A_FETCH1));

   p_spin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(A_FETCH1) && busy) |=> upc == UPC_W'(A_FETCH1));

   p_spin_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(A_LW + 3) && !busy) |=> upc == UPC_W'(A_LW + 4));

   p_group_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(A_ALU + 2) || upc == UPC_W'(A_JAL + 3)) |=> upc == UPC_W'(A_FETCH0));

   p_dispatch_br_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(A_FETCH2) && opcode == OP_W'(OPC_BR)) |=> upc == UPC_W'(A_BR));

   p_br_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(A_BR + 2) && !cond) |=> upc == UPC_W'(A_FETCH0));

   p_br_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UPC_W'(A_BR + 2) && cond) |=> upc == UPC_W'(A_BR + 3));

   p_trap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (illegal && $stable(upc)));

   p_no_mem_wr_r8: assert property (@(posedge clk) disable iff (!rst_n) !mem_wr);

endmodule

bind ucode_sequencer ucode_sequencer_chk #(.UPC_W(UPC_W), .OP_W(OP_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .upc     (upc_o),
   .opcode  (opcode_i),
   .cond    (cond_i),
   .busy    (busy_i),
   .illegal (illegal_o),
   .mem_wr  (ctrl_o[9])
);

// File: tb/ucode_sequencer_tb.sv
module ucode_sequencer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  opcode = '0;
   logic        cond = 1'b0;
   logic        busy = 1'b0;
   logic [17:0] ctrl;
   logic [5:0]  upc;
   logic        illegal;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ucode_sequencer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .opcode_i  (opcode),
      .cond_i    (cond),
      .busy_i    (busy),
      .ctrl_o    (ctrl),
      .upc_o     (upc),
      .illegal_o (illegal)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   // group start (-1 if none) and length, from the address map
   function automatic int g_start(input int op);
      case (op)
         12: return 3;
         4:  return 6;
         0:  return 9;
         27: return 14;
         24: return 18;
         default: return -1;
      endcase
   endfunction

   function automatic int g_len(input int op);
      case (op)
         12: return 3;
         4:  return 3;
         0:  return 5;
         27: return 4;
         default: return 6;
      endcase
   endfunction

   task automatic run(input int op, input int w, input bit c);
      int cur;
      int last;
      bit done;
      rst_n  = 1'b0;
      opcode = 5'(op);
      cond   = c;
      busy   = 1'b1;
      tick; tick;
      chk("R1 upc in reset", int'(upc), 0);
      chk("R1 fetch0 ma_ld", int'(ctrl[17]), 1);
      chk("R1 fetch0 a_ld", int'(ctrl[16]), 1);
      rst_n = 1'b1;
      tick;
      chk("R2 fetch0->fetch1 with busy high", int'(upc), 1);
      chk("R8 fetch1 ir_ld", int'(ctrl[14]), 1);
      for (int i = 0; i < w; i++) begin
         busy = 1'b1;
         tick;
         chk("R3 fetch1 holds on busy", int'(upc), 1);
      end
      busy = 1'b0;
      tick;
      chk("R3 fetch1 advances", int'(upc), 2);
      chk("R8 fetch2 pc_ld", int'(ctrl[13]), 1);
      chk("R8 fetch2 alu_op", int'(ctrl[2:0]), 1);
      busy = 1'b1;
      tick;
      if (g_start(op) < 0) begin
         chk("R7 trap address", int'(upc), 24);
         chk("R7 illegal high", int'(illegal), 1);
         for (int i = 0; i < 3; i++) begin
            busy = i[0];
            cond = ~cond;
            tick;
            chk("R7 trap holds", int'(upc), 24);
            chk("R7 illegal stays", int'(illegal), 1);
         end
      end else begin
         chk("R5 dispatch target", int'(upc), g_start(op));
         cur  = g_start(op);
         last = cur + g_len(op) - 1;
         done = 1'b0;
         while (!done) begin
            chk("R2 step address", int'(upc), cur);
            chk("R7 illegal low", int'(illegal), 0);
            chk("R8 no memory write", int'(ctrl[9]), 0);
            if (cur == 20) begin
               busy = 1'b1;
               tick;
               if (c) begin
                  chk("R6 taken falls through", int'(upc), 21);
                  cur = 21;
               end else begin
                  chk("R6 not taken returns", int'(upc), 0);
                  done = 1'b1;
               end
            end else if (cur == 12) begin
               for (int i = 0; i < w; i++) begin
                  busy = 1'b1;
                  tick;
                  chk("R3 load step holds on busy", int'(upc), 12);
               end
               busy = 1'b0;
               tick;
               cur = 13;
            end else if (cur == last) begin
               busy = 1'b1;
               tick;
               chk("R4 group end returns to fetch0", int'(upc), 0);
               done = 1'b1;
            end else begin
               busy = 1'b1;
               tick;
               cur++;
            end
         end
      end
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #3;
      for (int op = 0; op < 32; op++)
         for (int w = 0; w < 3; w++)
            for (int c = 0; c < 2; c++)
               run(op, w, c[0]);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule